// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the sequence of column addresses for one memory burst. A start command carries a starting column, a burst-length code and an ordering choice. The block then presents one column address per accepted beat on a valid/ready output stream. Fixed lengths of 1, 2, 4 and 8 beats are supported, in either sequential order (the low bits count up and wrap inside the aligned block) or interleaved order (the low bits are XORed with the beat index). There is also a full-page length. It walks the whole 512-column row modulo its size and runs until an explicit stop arrives.

A start may arrive on any clock, including in the middle of a running burst. It discards the current burst and restarts the sequence from the new column. The stop input ends the burst, as a memory controller does when it issues a burst-stop or a precharge. The start and stop pins are plain control inputs and are always accepted.

The output stream follows valid/ready rules. An address is transferred on a cycle where `col_valid` and `col_ready` are both high. While `col_ready` is low, the presented address, the valid strobe and the last flag hold steady. Only start and stop may override a stalled beat.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, and until the first start, `col_valid` and `col_last` are low.
- R2: A start sampled on a clock edge makes `col_valid` high in the next cycle, with `col_addr` equal to the sampled `start_col`. This holds even when a burst was already running, which is then abandoned.
- R3: With sequential order and a fixed length BL, beat n presents the start column with its low log2(BL) bits replaced by (start + n) mod BL. The upper bits are unchanged.
- R4: With interleaved order (`order_sel` = 1) and a fixed length BL, beat n presents the start column with its low log2(BL) bits XORed with n.
- R5: `bl_sel` values 0, 1, 2 and 3 select lengths 1, 2, 4 and 8. Any value from 4 to 7 selects full page. In full page, beat n presents (start + n) mod 512, the stream continues past 512 beats, and `col_last` never rises.
- R6: In full page, interleaved order is ignored and the sequence is identical to sequential order.
- R7: `col_last` is high exactly on beat BL-1 of a fixed-length burst. Once that beat is accepted without a start, `col_valid` is low in the next cycle.
- R8: A stop sampled without a start makes `col_valid` low in the next cycle. When start and stop are sampled together, the start wins.
- R9: While `col_valid` is high and `col_ready` is low, with neither start nor stop, `col_addr`, `col_last` and `col_valid` stay unchanged in the next cycle.
- R10: With length 1 (`bl_sel` = 0), the burst is a single beat that carries `col_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new burst (always accepted) |
| start_col | input | 9 | Starting column of the burst |
| bl_sel | input | 3 | Length code: 0..3 give 1,2,4,8 beats; 4..7 give full page |
| order_sel | input | 1 | 0 sequential, 1 interleaved |
| stop | input | 1 | End the running burst |
| col_ready | input | 1 | Consumer accepts the presented address |
| col_valid | output | 1 | An address is presented |
| col_addr | output | 9 | Column address of the current beat |
| col_last | output | 1 | Current beat is the final beat of a fixed burst |

## Verification
On every cycle, the assertions check three things. They check that a start loads the start column, that a stall freezes the stream, and that stop or an accepted final beat empties it. They also check that the address bits above the burst block never move and that full page never raises the last flag. The ordering arithmetic itself can only be shown by the bench's scenarios. These sweep every start column under every length and both orders, and cover a full-page run past the row end, a mid-burst restart, a simultaneous start and stop, and an irregular ready pattern.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int COL_W      = 9;
  localparam int LEN_CODE_W = 3;
  localparam int MAX_FIX_LOG = 3;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
  import bcg_pkg::*;
#(
  parameter int CW  = COL_W,
  parameter int LW  = LEN_CODE_W,
  parameter int MXL = MAX_FIX_LOG
) (
  input  logic [LW-1:0] code,
  output logic [CW-1:0] mask,
  output logic          full
);
  assign full = (int'(code) > MXL);

  for (genvar i = 0; i < CW; i++) begin : g_mask
    assign mask[i] = full | (i < int'(code));
  end
endmodule

// File: rtl/bcg_order_unit.sv
module bcg_order_unit
  import bcg_pkg::*;
#(
  parameter int CW      = COL_W,
  parameter bit HAS_ILV = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] base,
  input  logic [CW-1:0] beat,
  input  logic [CW-1:0] mask,
  input  logic          ilv,
  output logic [CW-1:0] addr
);
  logic [CW-1:0] seq_addr;
  assign seq_addr = (base & ~mask) | ((base + beat) & mask);

  if (HAS_ILV) begin : g_ilv
    assign addr = ilv ? (base ^ (beat & mask)) : seq_addr;
  end else begin : g_seq
    logic unused_ilv;
    assign unused_ilv = ilv;
    assign addr = seq_addr;
  end

  // R3 / R4: bits above the burst block follow the start column
  a_r3_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
    (addr & ~mask) == (base & ~mask));
endmodule

// File: rtl/bcg_beat_ctrl.sv
module bcg_beat_ctrl
  import bcg_pkg::*;
#(
  parameter int CW = COL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] start_col,
  input  logic [CW-1:0] dec_mask,
  input  logic          dec_full,
  input  logic          order_ilv,
  input  logic          stop,
  input  logic          ready,
  output logic          active,
  output logic [CW-1:0] base,
  output logic [CW-1:0] beat,
  output logic [CW-1:0] mask,
  output logic          ilv,
  output logic          full,
  output logic          last
);
  logic at_end;
  assign at_end = !full && (beat == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= '0;
      beat   <= '0;
      mask   <= '0;
      ilv    <= 1'b0;
      full   <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      base   <= start_col;
      beat   <= '0;
      mask   <= dec_mask;
      full   <= dec_full;
      ilv    <= order_ilv & ~dec_full;
    end else if (stop) begin
      active <= 1'b0;
    end else if (active && ready) begin
      if (at_end) active <= 1'b0;
      else        beat   <= beat + 1'b1;
    end
  end

  assign last = active && at_end;

  // R6: full page never runs interleaved
  a_r6_full_seq: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !ilv);
  // R5: counter stays inside the block in fixed mode
  a_r5_beat_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !full) |-> ((beat & ~mask) == '0));
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int CW  = COL_W,
  parameter int LW  = LEN_CODE_W,
  parameter int MXL = MAX_FIX_LOG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] start_col,
  input  logic [LW-1:0] bl_sel,
  input  logic          order_sel,
  input  logic          stop,
  input  logic          col_ready,
  output logic          col_valid,
  output logic [CW-1:0] col_addr,
  output logic          col_last
);
  logic [CW-1:0] dec_mask, base, beat, mask;
  logic          dec_full, ilv, full, active, last;

  bcg_len_decode #(.CW(CW), .LW(LW), .MXL(MXL)) u_dec (
    .code (bl_sel),
    .mask (dec_mask),
    .full (dec_full)
  );

  bcg_beat_ctrl #(.CW(CW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_col (start_col),
    .dec_mask  (dec_mask),
    .dec_full  (dec_full),
    .order_ilv (order_sel == ORD_ILV),
    .stop      (stop),
    .ready     (col_ready),
    .active    (active),
    .base      (base),
    .beat      (beat),
    .mask      (mask),
    .ilv       (ilv),
    .full      (full),
    .last      (last)
  );

  bcg_order_unit #(.CW(CW), .HAS_ILV(1'b1)) u_ord (
    .clk   (clk),
    .rst_n (rst_n),
    .base  (base),
    .beat  (beat),
    .mask  (mask),
    .ilv   (ilv),
    .addr  (col_addr)
  );

  assign col_valid = active;
  assign col_last  = last;

  // R1: nothing presented without a valid beat
  a_r1_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);
  // R2: start loads the column
  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (col_valid && col_addr == $past(start_col)));
  // R5: full page never flags a last beat
  a_r5_full_no_last: assert property (@(posedge clk) disable iff (!rst_n)
    (start && dec_full) |=> !col_last);
  // R7: accepted last beat empties the stream
  a_r7_last_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && col_ready && col_last && !start) |=> !col_valid);
  // R8: stop empties the stream
  a_r8_stop_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !col_valid);
  // R9: stall holds the stream
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_ready && !start && !stop) |=>
      (col_valid && $stable(col_addr) && $stable(col_last)));
endmodule

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [8:0] start_col = '0;
  logic [2:0] bl_sel = '0;
  logic       order_sel = 1'b0;
  logic       stop = 1'b0;
  logic       col_ready = 1'b1;
  logic       col_valid;
  logic [8:0] col_addr;
  logic       col_last;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  burst_col_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .bl_sel(bl_sel), .order_sel(order_sel), .stop(stop),
    .col_ready(col_ready), .col_valid(col_valid), .col_addr(col_addr),
    .col_last(col_last)
  );

  function automatic int exp_addr(int b, int code, int ord, int n);
    int len;
    if (code > 3) return (b + n) % 512;
    len = 1 << code;
    if (ord != 0) return b ^ n;
    return (b & ~(len - 1)) | ((b + n) & (len - 1));
  endfunction

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic do_start(int c, int code, int ord);
    @(negedge clk);
    start = 1'b1; start_col = 9'(c); bl_sel = 3'(code); order_sel = ord[0];
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic fixed_burst(int c, int code, int ord);
    int len = 1 << code;
    string rq = (code == 0) ? "R10" : (ord != 0 ? "R4" : "R3");
    do_start(c, code, ord);
    chk("R2", int'(col_valid), 1);
    for (int n = 0; n < len; n++) begin
      chk(rq, int'(col_addr), exp_addr(c, code, ord, n));
      chk("R7", int'(col_last), (n == len - 1) ? 1 : 0);
      @(negedge clk);
    end
    chk("R7", int'(col_valid), 0);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(col_valid), 0);
    chk("R1", int'(col_last), 0);

    // R3 R4 R10 R7: exhaustive start column sweep over fixed lengths
    for (int code = 0; code < 4; code++)
      for (int ord = 0; ord < 2; ord++)
        for (int c = 0; c < 512; c++)
          fixed_burst(c, code, ord);

    // R5 R6: full page past row end, each code 4..7, both orders
    for (int code = 4; code < 8; code++) begin
      for (int ord = 0; ord < 2; ord++) begin
        int c = 500 - code * 7;
        do_start(c, code, ord);
        for (int n = 0; n < 530; n++) begin
          chk(ord != 0 ? "R6" : "R5", int'(col_addr), (c + n) % 512);
          chk("R5", int'(col_last), 0);
          chk("R5", int'(col_valid), 1);
          @(negedge clk);
        end
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R8", int'(col_valid), 0);
      end
    end

    // R2: restart mid-burst
    do_start(16, 3, 0);
    @(negedge clk);
    @(negedge clk);
    do_start(37, 2, 1);
    for (int n = 0; n < 4; n++) begin
      chk("R2", int'(col_addr), exp_addr(37, 2, 1, n));
      chk("R7", int'(col_last), n == 3 ? 1 : 0);
      @(negedge clk);
    end
    chk("R7", int'(col_valid), 0);

    // R8: stop mid fixed burst, and start+stop together
    do_start(8, 3, 0);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R8", int'(col_valid), 0);
    do_start(8, 3, 0);
    @(negedge clk);
    start = 1'b1; stop = 1'b1; start_col = 9'd100; bl_sel = 3'd1; order_sel = 1'b0;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    chk("R8", int'(col_valid), 1);
    chk("R8", int'(col_addr), 100);

    // R9: irregular ready pattern on an 8-beat interleaved burst
    @(negedge clk);
    @(negedge clk);
    begin
      int n = 0;
      int k = 0;
      do_start(203, 3, 1);
      while (n < 8) begin
        logic r;
        chk("R9", int'(col_valid), 1);
        chk("R9", int'(col_addr), exp_addr(203, 3, 1, n));
        chk("R9", int'(col_last), n == 7 ? 1 : 0);
        r = ((k % 3) == 2) || ((k % 5) == 0);
        col_ready = r;
        @(negedge clk);
        if (r) n++;
        k++;
      end
      col_ready = 1'b1;
      chk("R7", int'(col_valid), 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule